// File: doc/BRIEF.md
# Programmable Chip-Select Group Decoder

This block decodes the address of a small embedded processor bus into active-low chip-selects for one group of external devices. A 16-bit group base register holds the upper address bits where the group starts. Each chip-select has its own control register with an enable bit, a size code and a write-protect bit. While the address strobe is active, each chip-select compares the high-order bus address against the base. The size code sets how many low base bits are left out of the compare. The address bit just above one select's span picks which select of the group answers.

When a select fires, the block also raises an internal data-acknowledge. A write into a write-protected region produces neither a select nor an acknowledge. Such a write instead raises a bus error, if the bus-error time-out function is enabled. Interrupt-acknowledge cycles never match. Until software first writes the base register, chip-select 0 answers every strobed cycle so that the boot device can be fetched from. Registers are reached through a separate peripheral port.

Top module: `csel_group_dec`

## Requirements
- R1: After reset the base register and every control register read 0, all `cs_n` bits are 1, and `dtack` and `berr` are 0.
- R2: Register index 0 is the base register: write data bits 15..1 are stored, and bit 0 always reads 0. Index 1+i is the control register of select i: bit 0 enable, bits 3..1 size code, bit 4 write-protect; its other bits read 0.
- R3: Until the base register has been written once, a strobed, non-interrupt-acknowledge cycle at any address asserts `cs_n[0]` and leaves every other select inactive.
- R4: Once the base has been written, select i asserts only when its enable bit is 1 and the address lies in [G + i*S, G + (i+1)*S). Here S = 2^(14+size) bytes and G is the base field (bits 15..1, standing for address bits 28..14) shifted left by 14, with its low bits cleared to a multiple of 2*S.
- R5: Outputs are registered. Results of a cycle sampled at a clock edge appear after that edge, and all outputs return to idle on the edge after `bus_as_n` goes high.
- R6: While `bus_iack` is 1, no select, acknowledge or bus error is produced.
- R7: `dtack` is 1 exactly when one select is asserted.
- R8: A write (`bus_rw`=0) that matches a write-protected select asserts no select and no `dtack`. `berr` is then equal to `bto_en`.
- R9: A read that matches a write-protected select selects it normally.
- R10: At most one `cs_n` bit is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register index (0 base, 1+i control of select i) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| bus_addr | input | 29 | Bus byte address |
| bus_as_n | input | 1 | Active-low address strobe |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_iack | input | 1 | Interrupt-acknowledge cycle flag |
| bto_en | input | 1 | Bus-error time-out function enabled |
| cs_n | output | 2 | Active-low chip-selects |
| dtack | output | 1 | Internal data-acknowledge |
| berr | output | 1 | Bus error on blocked write |

## Verification
The embedded assertions watch, on every cycle, that at most one select is low and that the acknowledge tracks the selects. They also check that strobe release, interrupt-acknowledge cycles and blocked writes leave the outputs quiet, and that a bus error only follows an enabled time-out. Only the bench scenarios can show the address windows themselves. The bench sweeps every size code with aligned and misaligned bases across region edges and wrap-around, and also covers the boot behaviour before the first base write, the register bit layout and the write-protect outcomes.

// File: rtl/csg_pkg.sv
package csg_pkg;
  localparam int CTRL_SZ_W = 3;
  localparam int CTRL_W    = CTRL_SZ_W + 2;

  // control register: bit0 enable, bits 3..1 size code, bit4 write-protect
  typedef struct packed {
    logic                 wprot;
    logic [CTRL_SZ_W-1:0] size;
    logic                 en;
  } csg_ctrl_t;
endpackage

// File: rtl/csg_regs.sv
module csg_regs
  import csg_pkg::*;
#(
  parameter int N_CS   = 2,
  parameter int BASE_W = 15,
  localparam int RW    = BASE_W + 1,
  localparam int REG_AW = $clog2(N_CS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REG_AW-1:0]      reg_addr,
  input  logic                   reg_we,
  input  logic [RW-1:0]          reg_wdata,
  output logic [RW-1:0]          reg_rdata,
  output logic [BASE_W-1:0]      base_o,
  output logic                   base_init_o,
  output csg_ctrl_t [N_CS-1:0]   ctrl_o
);
  logic [BASE_W-1:0]    base_q;
  logic                 init_q;
  csg_ctrl_t [N_CS-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      init_q <= 1'b0;
    end else if (reg_we && reg_addr == '0) begin
      base_q <= reg_wdata[RW-1:1];
      init_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < N_CS; i++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrl_q[i] <= '0;
      else if (reg_we && reg_addr == REG_AW'(i + 1))
        ctrl_q[i] <= csg_ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0)
      reg_rdata = {base_q, 1'b0};
    for (int i = 0; i < N_CS; i++)
      if (reg_addr == REG_AW'(i + 1))
        reg_rdata = RW'(ctrl_q[i]);
  end

  assign base_o      = base_q;
  assign base_init_o = init_q;
  assign ctrl_o      = ctrl_q;

  AST_RSVD_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> !reg_rdata[0]); // R2
endmodule

// File: rtl/csg_match.sv
module csg_match
  import csg_pkg::*;
#(
  parameter int ADDR_W   = 29,
  parameter int BASE_LSB = 14,
  parameter int N_CS     = 2,
  parameter int IDX      = 0,
  localparam int BASE_W  = ADDR_W - BASE_LSB,
  localparam int SEL_W   = $clog2(N_CS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic              base_init,
  input  csg_ctrl_t         ctrl,
  output logic              hit
);
  localparam logic [SEL_W-1:0] IDX_V = SEL_W'(IDX);

  // compare base field bits at or above size+SEL_W; select field just below
  function automatic logic window_hit(input logic [ADDR_W-1:0] a,
                                      input logic [BASE_W-1:0] b,
                                      input logic [CTRL_SZ_W-1:0] sz);
    logic              ok;
    logic [ADDR_W-1:0] sh;
    ok = 1'b1;
    for (int k = 0; k < BASE_W; k++)
      if (k >= int'(sz) + SEL_W && a[BASE_LSB+k] != b[k])
        ok = 1'b0;
    sh = a >> (BASE_LSB + int'(sz));
    if (sh[SEL_W-1:0] != IDX_V)
      ok = 1'b0;
    return ok;
  endfunction

  logic win;
  assign win = window_hit(addr, base, ctrl.size);

  if (IDX == 0) begin : g_boot
    assign hit = base_init ? (ctrl.en && win) : 1'b1;
  end else begin : g_norm
    assign hit = base_init && ctrl.en && win;
  end
endmodule

// File: rtl/csel_group_dec.sv
module csel_group_dec
  import csg_pkg::*;
#(
  parameter int ADDR_W   = 29,
  parameter int BASE_LSB = 14,
  parameter int N_CS     = 2,
  localparam int BASE_W  = ADDR_W - BASE_LSB,
  localparam int RW      = BASE_W + 1,
  localparam int REG_AW  = $clog2(N_CS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_as_n,
  input  logic              bus_rw,
  input  logic              bus_iack,
  input  logic              bto_en,
  output logic [N_CS-1:0]   cs_n,
  output logic              dtack,
  output logic              berr
);
  logic [BASE_W-1:0]    base;
  logic                 base_init;
  csg_ctrl_t [N_CS-1:0] ctrl;

  csg_regs #(.N_CS(N_CS), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .base_o(base),
    .base_init_o(base_init), .ctrl_o(ctrl)
  );

  // named internal events
  logic [N_CS-1:0] raw_hit;
  logic [N_CS-1:0] sel_ok;
  logic [N_CS-1:0] wr_blocked;
  logic [N_CS-1:0] cs_next;
  logic            cycle_live;

  for (genvar i = 0; i < N_CS; i++) begin : g_cs
    csg_match #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .N_CS(N_CS), .IDX(i)) u_match (
      .addr(bus_addr), .base(base), .base_init(base_init),
      .ctrl(ctrl[i]), .hit(raw_hit[i])
    );
    assign wr_blocked[i] = sel_ok[i] && ctrl[i].wprot && !bus_rw;
  end

  assign cycle_live = !bus_as_n && !bus_iack;
  assign sel_ok     = cycle_live ? raw_hit : '0;
  assign cs_next    = sel_ok & ~wr_blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n  <= '1;
      dtack <= 1'b0;
      berr  <= 1'b0;
    end else begin
      cs_n  <= ~cs_next;
      dtack <= |cs_next;
      berr  <= bto_en && |wr_blocked;
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R10
  AST_ACK_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    dtack == (cs_n != '1)); // R7
  AST_IDLE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as_n |=> (cs_n == '1 && !dtack && !berr)); // R5
  AST_IACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_iack |=> (cs_n == '1 && !dtack && !berr)); // R6
  AST_BERR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    berr |-> (!dtack && cs_n == '1)); // R8
  AST_BERR_NEEDS_TO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr) |-> $past(bto_en && !bus_rw)); // R8
endmodule

// File: tb/csel_group_dec_tb.sv
module csel_group_dec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [28:0] bus_addr = '0;
  logic        bus_as_n = 1'b1;
  logic        bus_rw = 1'b1;
  logic        bus_iack = 1'b0;
  logic        bto_en = 1'b0;
  logic [1:0]  cs_n;
  logic        dtack;
  logic        berr;

  int errors = 0;
  int checks = 0;

  // bench-side configuration model
  logic        m_init = 1'b0;
  logic [14:0] m_field = '0;
  logic        m_en [2];
  logic [2:0]  m_sz [2];
  logic        m_wp [2];

  always #4 clk = ~clk;

  csel_group_dec u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
    .bus_as_n(bus_as_n), .bus_rw(bus_rw), .bus_iack(bus_iack),
    .bto_en(bto_en), .cs_n(cs_n), .dtack(dtack), .berr(berr)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 2'd0) begin m_init = 1'b1; m_field = d[15:1]; end
    else begin m_en[a-1] = d[0]; m_sz[a-1] = d[3:1]; m_wp[a-1] = d[4]; end
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // arithmetic region model: returns select index or -1
  function automatic int exp_sel(input logic [28:0] a);
    longint s, g, gs;
    if (!m_init) return 0;
    for (int i = 0; i < 2; i++) begin
      s  = longint'(1) << (14 + m_sz[i]);
      gs = (longint'(m_field) << 14) / (2 * s) * (2 * s);
      if (m_en[i] && longint'(a) >= gs + i * s && longint'(a) < gs + (i + 1) * s)
        return i;
    end
    return -1;
  endfunction

  task automatic bus(input logic [28:0] a, input logic rw, input logic iack,
                     input logic bto, input string req);
    int       e;
    logic     blk;
    logic [1:0] ecs;
    e = iack ? -1 : exp_sel(a);
    blk = (e >= 0) && m_wp[e] && !rw;
    ecs = 2'b11;
    if (e >= 0 && !blk) ecs[e] = 1'b0;
    @(negedge clk);
    bus_addr = a; bus_rw = rw; bus_iack = iack; bto_en = bto; bus_as_n = 1'b0;
    #1;
    chk(cs_n == 2'b11 && !dtack, "R5 before edge", cs_n, 3);
    @(negedge clk);
    chk(cs_n == ecs, req, cs_n, ecs);
    chk(dtack == (ecs != 2'b11), "R7 dtack", dtack, ecs != 2'b11);
    chk(berr == (blk && bto), "R8 berr", berr, blk && bto);
    bus_as_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 2'b11 && !dtack && !berr, "R5 idle after release", {cs_n, dtack, berr}, 12);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [14:0] fields [3];
    fields[0] = 15'h0000; fields[1] = 15'h5A5A; fields[2] = 15'h7FFF;
    for (int i = 0; i < 2; i++) begin m_en[i] = 0; m_sz[i] = 0; m_wp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 2'b11 && !dtack && !berr, "R1 outputs", {cs_n, dtack, berr}, 12);
    for (int a = 0; a < 3; a++) rd_chk(2'(a), 16'h0000, "R1 register reset");

    // R3 boot select before base write, even with selects disabled
    bus(29'h0000000, 1'b1, 1'b0, 1'b0, "R3 boot read low");
    bus(29'h1ABCDEF, 1'b0, 1'b0, 1'b0, "R3 boot write high");
    bus(29'h1FFFFFF, 1'b1, 1'b1, 1'b0, "R6 iack in boot");

    // R2 register layout
    wr_reg(2'd1, 16'hFFFF);
    rd_chk(2'd1, 16'h001F, "R2 ctrl0 unused bits");
    wr_reg(2'd2, 16'hFFE2);
    rd_chk(2'd2, 16'h0002, "R2 ctrl1 unused bits");
    wr_reg(2'd1, 16'h0001);
    bus(29'h0123456, 1'b1, 1'b0, 1'b0, "R3 still boot after ctrl write");
    wr_reg(2'd0, 16'hFFFF);
    rd_chk(2'd0, 16'hFFFE, "R2 base reserved bit");

    // R4 disabled select never answers
    wr_reg(2'd0, {15'h0040, 1'b0});
    bus(29'h0100000, 1'b1, 1'b0, 1'b0, "R4 cs0 window");
    bus(29'h0104000, 1'b1, 1'b0, 1'b0, "R4 cs1 disabled");

    // R4 sweep over sizes, bases and region edges
    for (int sz = 0; sz < 8; sz++) begin
      wr_reg(2'd1, 16'(1 | (sz << 1)));
      wr_reg(2'd2, 16'(1 | (sz << 1)));
      for (int f = 0; f < 3; f++) begin
        longint s, g;
        wr_reg(2'd0, {fields[f], 1'b0});
        s = longint'(1) << (14 + sz);
        g = (longint'(fields[f]) << 14) / (2 * s) * (2 * s);
        bus(29'(g), 1'b1, 1'b0, 1'b0, "R4 cs0 first byte");
        bus(29'(g + s - 1), 1'b0, 1'b0, 1'b0, "R4 cs0 last byte");
        bus(29'(g + s), 1'b1, 1'b0, 1'b0, "R4 cs1 first byte");
        bus(29'(g + 2 * s - 1), 1'b0, 1'b0, 1'b0, "R4 cs1 last byte");
        bus(29'(g - 1), 1'b1, 1'b0, 1'b0, "R4 below group");
        bus(29'(g + 2 * s), 1'b1, 1'b0, 1'b0, "R4 above group");
      end
    end

    // R6 interrupt-acknowledge on a matching address
    wr_reg(2'd1, 16'h0001);
    wr_reg(2'd2, 16'h0001);
    wr_reg(2'd0, {15'h0100, 1'b0});
    bus(29'h0404000, 1'b1, 1'b0, 1'b0, "R4 cs1 reference");
    bus(29'h0404000, 1'b1, 1'b1, 1'b1, "R6 iack suppresses");

    // R8 / R9 write protect
    wr_reg(2'd1, 16'h0011);
    bus(29'h0400010, 1'b0, 1'b0, 1'b0, "R8 blocked write no timeout");
    bus(29'h0400010, 1'b0, 1'b0, 1'b1, "R8 blocked write with timeout");
    bus(29'h0400010, 1'b1, 1'b0, 1'b1, "R9 protected read");
    bus(29'h0404010, 1'b0, 1'b0, 1'b1, "R8 unprotected neighbour write");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule